// File: doc/BRIEF.md
# Two-Stage Memory Access Guard

This block sits beside a processor core's load, store and instruction-fetch path. It judges every access against two independent tables of address windows. The guest operating system owns the first table. Only hypervisor-level code may change the second table. An access is allowed only when both tables agree. Addresses are never remapped: the block only decides whether an access may proceed. It does not produce a new address.

Each window covers a span of 64-byte granules, from a base granule to a limit granule. Each window has an enable bit and six permission bits: read, write and execute, given separately for unprivileged and privileged code. Within one table, the lowest-numbered window that covers the address decides the outcome. An address that no window covers is refused, unless that table's background-allow bit is set. The decision is registered.

A denied access leaves a sticky fault record. The record holds the faulting stage, the address and the access kind, and stays until software clears it. A table write issued from too low a privilege level is dropped, and an error pulse flags it.

Top module: `mem_guard2`

## Requirements
- R1: A request sampled at a rising edge with `req_valid_i` high produces `rsp_valid_o` high and its verdict on `rsp_allow_o` in the following cycle. Without a request, both outputs are low in that cycle.
- R2: A window matches when it is enabled and `addr[AW-1:6]` lies between its base and limit granules, inclusive. Register selects are 0 = base, 1 = limit, 2 = attributes and 3 = background. Base and limit take `wdata[AW-1:6]`; background takes `wdata[0]`.
- R3: The attribute bits are: 0 enable, 1/2/3 unprivileged read/write/execute, 4/5/6 privileged read/write/execute. A level of 0 on `cur_el_i` is unprivileged; any other level is privileged. Access kinds are 0 = read, 1 = write, 2 = fetch.
- R4: When several enabled windows of one stage match, the lowest-numbered one alone decides.
- R5: When no window of a stage matches, that stage allows the access only if its background bit is 1. After reset, all windows are disabled and both background bits are 0.
- R6: An access is allowed only when stage 1 and stage 2 both allow it. Stage 2 can refuse what stage 1 permits.
- R7: Stage 1 writes are accepted only when `cur_el_i >= 1`, and stage 2 writes only when `cur_el_i >= 2`. A rejected write changes nothing, and `cfg_err_o` is high for exactly the cycle after it.
- R8: On a refused access with no fault held, the block captures the stage (0 = stage 1, 1 = stage 2; stage 2 is reported when both refuse), the unmodified address and the kind. It holds them while later faults arrive.
- R9: `fault_clr_i` drops the held record. A refusal in the same cycle as a clear is captured as the new record.
- R10: Access kind 3 is always refused.
- R11: With `S2_REGIONS = 0`, stage 2 is absent and the verdict is stage 1 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request present |
| req_addr_i | input | AW | Access address |
| req_kind_i | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| cur_el_i | input | 2 | Current exception level of the core |
| s1_we_i | input | 1 | Stage 1 table write strobe |
| s1_idx_i | input | 5 | Stage 1 window index |
| s1_sel_i | input | 2 | Stage 1 register select |
| s1_wdata_i | input | AW | Stage 1 write data |
| s2_we_i | input | 1 | Stage 2 table write strobe |
| s2_idx_i | input | 5 | Stage 2 window index |
| s2_sel_i | input | 2 | Stage 2 register select |
| s2_wdata_i | input | AW | Stage 2 write data |
| fault_clr_i | input | 1 | Clear the fault record |
| rsp_valid_o | output | 1 | Verdict valid |
| rsp_allow_o | output | 1 | Access allowed |
| cfg_err_o | output | 1 | Rejected table write pulse |
| fault_valid_o | output | 1 | Fault record held |
| fault_stage_o | output | 1 | Faulting stage, 0 = stage 1, 1 = stage 2 |
| fault_addr_o | output | AW | Faulting address |
| fault_kind_o | output | 2 | Faulting access kind |

## Verification
The bench probes window edges: the first and last byte of a window and the bytes just outside it. These separate an off-by-one in the granule compare from a correct inclusive limit. The same address is issued from level 0 and level 1 and with each access kind. These show which permission triple is selected and that the reserved kind is refused. Overlapping windows with conflicting rights expose a reversed priority. A second instance without stage 2, fed the same stimulus, shows the bypass against the main instance, which refuses while its stage 2 is still empty.

// File: rtl/mem_guard2_pkg.sv
package mem_guard2_pkg;
  localparam int GRAN_BITS = 6;
  localparam int ATTR_W    = 7;
  localparam int IDX_W     = 5;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_ATTR  = 2'd2,
    SEL_BG    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mem_guard2_table.sv
module mem_guard2_table
  import mem_guard2_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       sel_i,
  input  logic [AW-1:0]    wdata_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [1:0]       kind_i,
  input  logic             priv_i,
  output logic             allow_o
);
  localparam int GW  = AW - GRAN_BITS;
  localparam int AIW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [GW-1:0]     base_q  [NREG];
  logic [GW-1:0]     limit_q [NREG];
  logic [ATTR_W-1:0] attr_q  [NREG];
  logic              bg_q;

  logic [AIW-1:0] slot;
  logic           slot_ok;
  assign slot    = idx_i[AIW-1:0];
  assign slot_ok = 32'(idx_i) < NREG;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bg_q <= 1'b0;
      for (int i = 0; i < NREG; i++) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
        attr_q[i]  <= '0;
      end
    end else if (we_i) begin
      if (reg_sel_e'(sel_i) == SEL_BG) begin
        bg_q <= wdata_i[0];
      end else if (slot_ok) begin
        case (reg_sel_e'(sel_i))
          SEL_BASE:  base_q[slot]  <= wdata_i[AW-1:GRAN_BITS];
          SEL_LIMIT: limit_q[slot] <= wdata_i[AW-1:GRAN_BITS];
          default:   attr_q[slot]  <= wdata_i[ATTR_W-1:0];
        endcase
      end
    end
  end

  // walk downward so the lowest matching index is the last one to assign
  logic [GW-1:0]     gran;
  logic              hit;
  logic [ATTR_W-1:0] hit_attr;
  assign gran = addr_i[AW-1:GRAN_BITS];

  always_comb begin
    hit      = 1'b0;
    hit_attr = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (attr_q[i][0] && gran >= base_q[i] && gran <= limit_q[i]) begin
        hit      = 1'b1;
        hit_attr = attr_q[i];
      end
    end
  end

  logic [2:0] perm;
  logic       perm_ok;
  assign perm = priv_i ? hit_attr[6:4] : hit_attr[3:1];

  always_comb begin
    case (acc_kind_e'(kind_i))
      ACC_READ:  perm_ok = perm[0];
      ACC_WRITE: perm_ok = perm[1];
      ACC_FETCH: perm_ok = perm[2];
      default:   perm_ok = 1'b0;
    endcase
  end

  assign allow_o = (acc_kind_e'(kind_i) != ACC_RSVD) && (hit ? perm_ok : bg_q);
endmodule

// File: rtl/mem_guard2.sv
module mem_guard2
  import mem_guard2_pkg::*;
#(
  parameter int AW         = 32,
  parameter int S1_REGIONS = 8,
  parameter int S2_REGIONS = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_kind_i,
  input  logic [1:0]    cur_el_i,
  input  logic          s1_we_i,
  input  logic [4:0]    s1_idx_i,
  input  logic [1:0]    s1_sel_i,
  input  logic [AW-1:0] s1_wdata_i,
  input  logic          s2_we_i,
  input  logic [4:0]    s2_idx_i,
  input  logic [1:0]    s2_sel_i,
  input  logic [AW-1:0] s2_wdata_i,
  input  logic          fault_clr_i,
  output logic          rsp_valid_o,
  output logic          rsp_allow_o,
  output logic          cfg_err_o,
  output logic          fault_valid_o,
  output logic          fault_stage_o,
  output logic [AW-1:0] fault_addr_o,
  output logic [1:0]    fault_kind_o
);
  logic priv;
  logic s1_we_ok, s2_we_ok, wr_reject;
  logic s1_allow, s2_allow;

  assign priv      = cur_el_i != 2'd0;
  assign s1_we_ok  = s1_we_i && (cur_el_i >= 2'd1);
  assign s2_we_ok  = s2_we_i && (cur_el_i >= 2'd2);
  assign wr_reject = (s1_we_i && !s1_we_ok) || (s2_we_i && !s2_we_ok);

  mem_guard2_table #(.NREG(S1_REGIONS), .AW(AW)) u_stage1 (
    .clk_i, .rst_ni,
    .we_i    (s1_we_ok),
    .idx_i   (s1_idx_i),
    .sel_i   (s1_sel_i),
    .wdata_i (s1_wdata_i),
    .addr_i  (req_addr_i),
    .kind_i  (req_kind_i),
    .priv_i  (priv),
    .allow_o (s1_allow)
  );

  generate
    if (S2_REGIONS > 0) begin : g_stage2
      mem_guard2_table #(.NREG(S2_REGIONS), .AW(AW)) u_stage2 (
        .clk_i, .rst_ni,
        .we_i    (s2_we_ok),
        .idx_i   (s2_idx_i),
        .sel_i   (s2_sel_i),
        .wdata_i (s2_wdata_i),
        .addr_i  (req_addr_i),
        .kind_i  (req_kind_i),
        .priv_i  (priv),
        .allow_o (s2_allow)
      );
    end else begin : g_no_stage2
      logic unused_s2;
      assign unused_s2 = ^{s2_we_ok, s2_idx_i, s2_sel_i, s2_wdata_i};
      assign s2_allow  = 1'b1;
    end
  endgenerate

  logic deny;
  assign deny = req_valid_i && !(s1_allow && s2_allow);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_allow_o   <= 1'b0;
      cfg_err_o     <= 1'b0;
      fault_valid_o <= 1'b0;
      fault_stage_o <= 1'b0;
      fault_addr_o  <= '0;
      fault_kind_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_allow_o <= req_valid_i && s1_allow && s2_allow;
      cfg_err_o   <= wr_reject;
      if (deny && (!fault_valid_o || fault_clr_i)) begin
        fault_valid_o <= 1'b1;
        fault_stage_o <= !s2_allow;  // stage 2 outranks stage 1
        fault_addr_o  <= req_addr_i;
        fault_kind_o  <= req_kind_i;
      end else if (fault_clr_i) begin
        fault_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mem_guard2_sva.sv
module mem_guard2_sva #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [AW-1:0] req_addr_i,
  input logic [1:0]    req_kind_i,
  input logic [1:0]    cur_el_i,
  input logic          s1_we_i,
  input logic          s2_we_i,
  input logic          fault_clr_i,
  input logic          rsp_valid_o,
  input logic          rsp_allow_o,
  input logic          cfg_err_o,
  input logic          fault_valid_o,
  input logic [AW-1:0] fault_addr_o,
  input logic [1:0]    fault_kind_o
);
  a_r1_verdict_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r1_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !rsp_allow_o);

  a_r10_rsvd_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd3) |=> !rsp_allow_o);

  a_r7_s2_low_el_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_we_i && cur_el_i < 2'd2) |=> cfg_err_o);

  a_r7_no_write_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s1_we_i && !s2_we_i) |=> !cfg_err_o);

  a_r8_deny_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_allow_o) |-> fault_valid_o);

  a_r8_record_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_valid_o && !fault_clr_i) |=>
      fault_valid_o && $stable(fault_addr_o) && $stable(fault_kind_o));

  a_r9_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_clr_i && !req_valid_i) |=> !fault_valid_o);
endmodule

bind mem_guard2 mem_guard2_sva #(.AW(AW)) u_sva (.*);

// File: tb/mem_guard2_bench.sv
module mem_guard2_bench;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [1:0]    req_kind_i = '0;
  logic [1:0]    cur_el_i = '0;
  logic          s1_we_i = 1'b0, s2_we_i = 1'b0;
  logic [4:0]    s1_idx_i = '0, s2_idx_i = '0;
  logic [1:0]    s1_sel_i = '0, s2_sel_i = '0;
  logic [AW-1:0] s1_wdata_i = '0, s2_wdata_i = '0;
  logic          fault_clr_i = 1'b0;

  logic          rsp_valid_o, rsp_allow_o, cfg_err_o, fault_valid_o, fault_stage_o;
  logic [AW-1:0] fault_addr_o;
  logic [1:0]    fault_kind_o;
  logic          nb_rsp_valid, nb_rsp_allow, nb_cfg_err, nb_fault_valid, nb_fault_stage;
  logic [AW-1:0] nb_fault_addr;
  logic [1:0]    nb_fault_kind;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  mem_guard2 #(.AW(AW), .S1_REGIONS(8), .S2_REGIONS(8)) u_mem_guard2 (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_kind_i, .cur_el_i,
    .s1_we_i, .s1_idx_i, .s1_sel_i, .s1_wdata_i,
    .s2_we_i, .s2_idx_i, .s2_sel_i, .s2_wdata_i, .fault_clr_i,
    .rsp_valid_o, .rsp_allow_o, .cfg_err_o, .fault_valid_o, .fault_stage_o,
    .fault_addr_o, .fault_kind_o
  );

  mem_guard2 #(.AW(AW), .S1_REGIONS(8), .S2_REGIONS(0)) u_no_s2 (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_kind_i, .cur_el_i,
    .s1_we_i, .s1_idx_i, .s1_sel_i, .s1_wdata_i,
    .s2_we_i, .s2_idx_i, .s2_sel_i, .s2_wdata_i, .fault_clr_i,
    .rsp_valid_o (nb_rsp_valid), .rsp_allow_o (nb_rsp_allow), .cfg_err_o (nb_cfg_err),
    .fault_valid_o (nb_fault_valid), .fault_stage_o (nb_fault_stage),
    .fault_addr_o (nb_fault_addr), .fault_kind_o (nb_fault_kind)
  );

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input bit stage2, input int idx, input int sel, input logic [AW-1:0] data,
                    input logic [1:0] el, output logic err);
    cur_el_i = el;
    if (stage2) begin
      s2_we_i = 1'b1; s2_idx_i = 5'(idx); s2_sel_i = 2'(sel); s2_wdata_i = data;
    end else begin
      s1_we_i = 1'b1; s1_idx_i = 5'(idx); s1_sel_i = 2'(sel); s1_wdata_i = data;
    end
    @(negedge clk_i);
    s1_we_i = 1'b0; s2_we_i = 1'b0;
    err = cfg_err_o;
  endtask

  task automatic prog(input bit stage2, input int idx, input logic [AW-1:0] base,
                      input logic [AW-1:0] limit, input logic [6:0] attr);
    logic e;
    wr(stage2, idx, 0, base, 2'd2, e);
    wr(stage2, idx, 1, limit, 2'd2, e);
    wr(stage2, idx, 2, {25'd0, attr}, 2'd2, e);
  endtask

  task automatic acc(input logic [AW-1:0] a, input logic [1:0] k, input logic [1:0] el,
                     input bit clr, output logic allow);
    req_valid_i = 1'b1; req_addr_i = a; req_kind_i = k; cur_el_i = el; fault_clr_i = clr;
    @(negedge clk_i);
    req_valid_i = 1'b0; fault_clr_i = 1'b0;
    allow = rsp_allow_o;
  endtask

  task automatic clear_fault();
    fault_clr_i = 1'b1;
    @(negedge clk_i);
    fault_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    logic al;
    check("R1 reset rsp_valid", AW'(rsp_valid_o), 0);
    check("R8 reset fault_valid", AW'(fault_valid_o), 0);
    check("R7 reset cfg_err", AW'(cfg_err_o), 0);
    acc(32'h1000, 2'd0, 2'd1, 1'b0, al);
    check("R1 rsp_valid after request", AW'(rsp_valid_o), 1);
    check("R5 reset state refuses", AW'(al), 0);
    @(negedge clk_i);
    check("R1 rsp_valid idle", AW'(rsp_valid_o), 0);
    clear_fault();
  endtask

  task automatic t_range();
    logic al, e;
    prog(1'b0, 0, 32'h1000, 32'h1FC0, 7'h7F);
    acc(32'h1000, 2'd0, 2'd1, 1'b0, al);
    check("R6 empty stage 2 refuses", AW'(al), 0);
    check("R11 no stage 2 allows", AW'(nb_rsp_allow), 1);
    check("R8 stage 2 fault stage", AW'(fault_stage_o), 1);
    clear_fault();
    wr(1'b1, 0, 3, 32'h1, 2'd2, e);
    check("R7 EL2 stage 2 write no err", AW'(e), 0);
    acc(32'h1000, 2'd0, 2'd1, 1'b0, al); check("R2 window first byte", AW'(al), 1);
    acc(32'h1FFF, 2'd0, 2'd1, 1'b0, al); check("R2 window last byte", AW'(al), 1);
    acc(32'h2000, 2'd0, 2'd1, 1'b0, al); check("R2 past limit", AW'(al), 0);
    clear_fault();
    acc(32'h0FFF, 2'd0, 2'd1, 1'b0, al); check("R2 below base", AW'(al), 0);
    clear_fault();
  endtask

  task automatic t_attr();
    logic al;
    prog(1'b0, 1, 32'h3000, 32'h3000, 7'h73);
    acc(32'h3000, 2'd0, 2'd0, 1'b0, al); check("R3 EL0 read", AW'(al), 1);
    acc(32'h3000, 2'd1, 2'd0, 1'b0, al); check("R3 EL0 write", AW'(al), 0);
    clear_fault();
    acc(32'h3000, 2'd2, 2'd0, 1'b0, al); check("R3 EL0 fetch", AW'(al), 0);
    clear_fault();
    acc(32'h3000, 2'd1, 2'd1, 1'b0, al); check("R3 EL1 write", AW'(al), 1);
    acc(32'h3000, 2'd2, 2'd1, 1'b0, al); check("R3 EL1 fetch", AW'(al), 1);
  endtask

  task automatic t_priority();
    logic al;
    prog(1'b0, 2, 32'h3000, 32'h3FC0, 7'h7F);
    acc(32'h3010, 2'd1, 2'd0, 1'b0, al); check("R4 lower index wins", AW'(al), 0);
    clear_fault();
    acc(32'h3040, 2'd1, 2'd0, 1'b0, al); check("R4 higher index alone", AW'(al), 1);
  endtask

  task automatic t_rsvd();
    logic al;
    acc(32'h1000, 2'd3, 2'd1, 1'b0, al); check("R10 reserved kind", AW'(al), 0);
    clear_fault();
  endtask

  task automatic t_stage2();
    logic al;
    prog(1'b1, 0, 32'h1000, 32'h1000, 7'h11);
    acc(32'h1000, 2'd0, 2'd1, 1'b0, al); check("R6 stage 2 allows read", AW'(al), 1);
    acc(32'h1000, 2'd1, 2'd1, 1'b0, al); check("R6 stage 2 refuses write", AW'(al), 0);
    check("R11 bypass allows write", AW'(nb_rsp_allow), 1);
    clear_fault();
    acc(32'h1040, 2'd1, 2'd1, 1'b0, al); check("R5 stage 2 background", AW'(al), 1);
  endtask

  task automatic t_fault();
    logic al;
    acc(32'h1008, 2'd1, 2'd1, 1'b0, al);
    check("R8 valid", AW'(fault_valid_o), 1);
    check("R8 stage", AW'(fault_stage_o), 1);
    check("R8 address", fault_addr_o, 32'h1008);
    check("R8 kind", AW'(fault_kind_o), 1);
    acc(32'h0FC4, 2'd0, 2'd1, 1'b0, al);
    check("R8 held address", fault_addr_o, 32'h1008);
    check("R8 held kind", AW'(fault_kind_o), 1);
    clear_fault();
    check("R9 cleared", AW'(fault_valid_o), 0);
    acc(32'h0FC4, 2'd0, 2'd1, 1'b0, al);
    check("R8 stage 1 fault", AW'(fault_stage_o), 0);
    acc(32'h2004, 2'd2, 2'd1, 1'b1, al);
    check("R9 clear with refusal valid", AW'(fault_valid_o), 1);
    check("R9 clear with refusal address", fault_addr_o, 32'h2004);
    check("R9 clear with refusal kind", AW'(fault_kind_o), 2);
    clear_fault();
    prog(1'b1, 1, 32'h5000, 32'h5000, 7'h01);
    acc(32'h5000, 2'd0, 2'd1, 1'b0, al);
    check("R8 both refuse reports stage 2", AW'(fault_stage_o), 1);
    clear_fault();
  endtask

  task automatic t_privilege();
    logic al, e;
    wr(1'b0, 0, 3, 32'h1, 2'd0, e);
    check("R7 EL0 stage 1 write err", AW'(e), 1);
    @(negedge clk_i);
    check("R7 err is one cycle", AW'(cfg_err_o), 0);
    acc(32'h8000, 2'd0, 2'd1, 1'b0, al);
    check("R7 rejected stage 1 write ignored", AW'(al), 0);
    clear_fault();
    wr(1'b1, 0, 3, 32'h0, 2'd1, e);
    check("R7 EL1 stage 2 write err", AW'(e), 1);
    acc(32'h1040, 2'd0, 2'd1, 1'b0, al);
    check("R7 rejected stage 2 write ignored", AW'(al), 1);
    wr(1'b0, 7, 2, 32'h0, 2'd1, e);
    check("R7 EL1 stage 1 write no err", AW'(e), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_range();
    t_attr();
    t_priority();
    t_rsvd();
    t_stage2();
    t_fault();
    t_privilege();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200us;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule